// File: doc/BRIEF.md
# I2C Controller Control Word and SCL Prescaler

This block is the control and status slice of a multi-master I2C controller. It keeps an 8-bit control word that software reaches through a simple write and read port. The word holds an acknowledge enable, a prescaler source select, an interrupt enable, a sticky pending flag and a 4-bit clock divider. The block also turns the peripheral clock into a single-cycle tick at twice the SCL rate. The byte engine uses that tick to place the high and low phases of SCL.

The byte engine reports three kinds of event: a finished byte, an address or general-call match, and a lost arbitration. Any of them sets the pending flag. While the flag is set, the block asks the bus to hold SCL low, which stalls the transfer by clock stretching. Software resumes the transfer by writing a zero into the flag. The block also tells the byte engine what to drive on SDA in the acknowledge slot, and it raises an interrupt when both the interrupt enable and the pending flag are set.

Top module: `i2c_ctl_regs`

## Requirements
- R1: After reset, rd_data reads 0x0F (all flags 0, divider 15), and irq, scl_hold and cfg_err are 0. ack_sda reads 1, which means released.
- R2: A write with wr_en stores the control word at the clock edge, and rd_data shows the stored word from the next cycle. The fields are: bit 7 acknowledge enable, bit 6 slow source select, bit 5 interrupt enable, bit 4 pending flag, bits 3:0 divider N.
- R3: With bit 6 = 0 (fast source), a divider code of 0 or 1 is stored as 2 and sets cfg_err. cfg_err is sticky and only reset clears it. With bit 6 = 1, codes 0 and 1 are stored unchanged.
- R4: scl_tick is a one-cycle pulse with a period of H*(N+1) clock cycles, where H = 8 for the fast source and H = 256 for the slow source. After any write, the first pulse comes H*(N+1) cycles after the write edge, because a write restarts both counter stages.
- R5: A one-cycle pulse on ev_byte_done, ev_addr_match or ev_arb_lost sets the pending flag (rd_data bit 4) at that edge.
- R6: A write with bit 4 = 0 clears the pending flag. A write with bit 4 = 1 does not change the flag, whether the flag is set or clear.
- R7: scl_hold is 1 exactly while the pending flag reads 1.
- R8: If an event and a clearing write fall in the same cycle, the pending flag is 1 afterwards.
- R9: irq is set one cycle after interrupt enable and the pending flag are both 1. With interrupt enable at 0, irq stays 0 while the pending flag is still recorded.
- R10: ack_sda is 0 (SDA driven low) one cycle after acknowledge enable and rx_mode are both 1. In every other case it is 1 (SDA released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Control word to write |
| rd_data | output | 8 | Current control word |
| cfg_err | output | 1 | Sticky flag for a clamped illegal divider code |
| ev_byte_done | input | 1 | A byte transmit or receive has finished |
| ev_addr_match | input | 1 | A slave address or general call has matched |
| ev_arb_lost | input | 1 | Arbitration was lost |
| rx_mode | input | 1 | The byte engine is receiving |
| scl_tick | output | 1 | Pulse at twice the SCL rate |
| scl_hold | output | 1 | Hold SCL low (stall) |
| ack_sda | output | 1 | SDA value for the acknowledge slot (0 = drive low) |
| irq | output | 1 | Interrupt request |

## Verification
The pending flag can be set by a bus event and cleared by a software write in the same cycle. The bench provokes this by pulsing ev_byte_done in the same cycle as a write with bit 4 = 0. It then expects the flag and scl_hold to read 1, since the event must not be lost. A divider write can also land while ticks are being timed. The scoreboard therefore restarts its interval count on every write and expects a first interval of one cycle more than the steady period, because the monitor sees the registered tick one edge later.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int DIV_W  = 4;
  localparam int WORD_W = 8;

  // Positions of the control-word fields
  localparam int B_ACK  = 7;
  localparam int B_SLOW = 6;
  localparam int B_IE   = 5;
  localparam int B_PEND = 4;

  typedef struct packed {
    logic             ack_en;
    logic             slow_src;
    logic             irq_en;
    logic             pend;
    logic [DIV_W-1:0] div;
  } ctl_word_t;
endpackage

// File: rtl/i2c_ctl_word.sv
module i2c_ctl_word
  import i2c_ctl_pkg::*;
#(
  parameter int MIN_FAST_DIV = 2,
  parameter int RESET_DIV    = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              ev_byte_done,
  input  logic              ev_addr_match,
  input  logic              ev_arb_lost,
  output ctl_word_t         word,
  output logic              cfg_err
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(MIN_FAST_DIV);
  localparam logic [DIV_W-1:0] RST_DIV = DIV_W'(RESET_DIV);

  logic             ev_any;
  logic             wr_clear;
  logic             bad_div;
  logic [DIV_W-1:0] new_div;

  assign ev_any   = ev_byte_done | ev_addr_match | ev_arb_lost;
  assign wr_clear = wr_en & ~wr_data[B_PEND];
  assign bad_div  = ~wr_data[B_SLOW] & (wr_data[DIV_W-1:0] < MIN_DIV);
  assign new_div  = bad_div ? MIN_DIV : wr_data[DIV_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      word.ack_en   <= 1'b0;
      word.slow_src <= 1'b0;
      word.irq_en   <= 1'b0;
      word.div      <= RST_DIV;
      cfg_err       <= 1'b0;
    end else if (wr_en) begin
      word.ack_en   <= wr_data[B_ACK];
      word.slow_src <= wr_data[B_SLOW];
      word.irq_en   <= wr_data[B_IE];
      word.div      <= new_div;
      if (bad_div) cfg_err <= 1'b1;
    end
  end

  // Pending flag: an event wins over a clearing write
  always_ff @(posedge clk) begin
    if (rst)           word.pend <= 1'b0;
    else if (ev_any)   word.pend <= 1'b1;
    else if (wr_clear) word.pend <= 1'b0;
  end

  p_event_sets_pend_r5: assert property (@(posedge clk) disable iff (rst)
    ev_any |=> word.pend);

  p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (ev_any && wr_en && !wr_data[B_PEND]) |=> word.pend);

  p_write_one_no_set_r6: assert property (@(posedge clk) disable iff (rst)
    (!word.pend && !ev_any && wr_en && wr_data[B_PEND]) |=> !word.pend);

  p_clear_releases_r6: assert property (@(posedge clk) disable iff (rst)
    (word.pend && !ev_any && wr_en && !wr_data[B_PEND]) |=> !word.pend);

  p_fast_div_legal_r3: assert property (@(posedge clk) disable iff (rst)
    word.slow_src || (word.div >= MIN_DIV));

  p_cfg_err_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);
endmodule

// File: rtl/i2c_ctl_prescale.sv
module i2c_ctl_prescale #(
  parameter int FAST_PRE = 16,
  parameter int SLOW_PRE = 512,
  parameter int DIV_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload,
  input  logic             slow_src,
  input  logic [DIV_W-1:0] div_val,
  output logic             scl_tick
);
  // The tick runs at twice the SCL rate, so each stage counts half a pre-divide
  localparam int FAST_HALF = FAST_PRE / 2;
  localparam int SLOW_HALF = SLOW_PRE / 2;
  localparam int MAX_HALF  = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
  localparam int PRE_W     = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_lim;
  logic [DIV_W-1:0] div_cnt;
  logic             pre_wrap;

  assign pre_lim  = slow_src ? PRE_W'(SLOW_HALF - 1) : PRE_W'(FAST_HALF - 1);
  assign pre_wrap = (pre_cnt == pre_lim);

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      pre_cnt  <= '0;
      div_cnt  <= '0;
      scl_tick <= 1'b0;
    end else begin
      scl_tick <= 1'b0;
      if (pre_wrap) begin
        pre_cnt <= '0;
        if (div_cnt == div_val) begin
          div_cnt  <= '0;
          scl_tick <= 1'b1;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  p_tick_single_r4: assert property (@(posedge clk) disable iff (rst)
    scl_tick |=> !scl_tick);

  p_pre_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= PRE_W'(MAX_HALF - 1));
endmodule

// File: rtl/i2c_ctl_pins.sv
module i2c_ctl_pins (
  input  logic clk,
  input  logic rst,
  input  logic ack_en,
  input  logic irq_en,
  input  logic pend,
  input  logic rx_mode,
  output logic ack_sda,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ack_sda <= 1'b1;
      irq     <= 1'b0;
    end else begin
      ack_sda <= ~(ack_en & rx_mode);
      irq     <= irq_en & pend;
    end
  end

  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);

  p_tx_releases_sda_r10: assert property (@(posedge clk) disable iff (rst)
    !rx_mode |=> ack_sda);
endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
  import i2c_ctl_pkg::*;
#(
  parameter int FAST_PRE     = 16,
  parameter int SLOW_PRE     = 512,
  parameter int MIN_FAST_DIV = 2,
  parameter int RESET_DIV    = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              cfg_err,
  input  logic              ev_byte_done,
  input  logic              ev_addr_match,
  input  logic              ev_arb_lost,
  input  logic              rx_mode,
  output logic              scl_tick,
  output logic              scl_hold,
  output logic              ack_sda,
  output logic              irq
);
  ctl_word_t word;

  i2c_ctl_word #(
    .MIN_FAST_DIV(MIN_FAST_DIV),
    .RESET_DIV   (RESET_DIV)
  ) u_word (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .ev_byte_done (ev_byte_done),
    .ev_addr_match(ev_addr_match),
    .ev_arb_lost  (ev_arb_lost),
    .word         (word),
    .cfg_err      (cfg_err)
  );

  i2c_ctl_prescale #(
    .FAST_PRE(FAST_PRE),
    .SLOW_PRE(SLOW_PRE),
    .DIV_W   (DIV_W)
  ) u_prescale (
    .clk     (clk),
    .rst     (rst),
    .reload  (wr_en),
    .slow_src(word.slow_src),
    .div_val (word.div),
    .scl_tick(scl_tick)
  );

  i2c_ctl_pins u_pins (
    .clk    (clk),
    .rst    (rst),
    .ack_en (word.ack_en),
    .irq_en (word.irq_en),
    .pend   (word.pend),
    .rx_mode(rx_mode),
    .ack_sda(ack_sda),
    .irq    (irq)
  );

  assign rd_data  = word;
  assign scl_hold = word.pend;

  p_stall_while_pend_r7: assert property (@(posedge clk) disable iff (rst)
    (scl_hold && !wr_en) |=> scl_hold);
endmodule

// File: tb/test_i2c_ctl_regs.sv
module test_i2c_ctl_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       cfg_err;
  logic       ev_byte_done = 1'b0;
  logic       ev_addr_match = 1'b0;
  logic       ev_arb_lost = 1'b0;
  logic       rx_mode = 1'b0;
  logic       scl_tick, scl_hold, ack_sda, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int exp_q[$];
  int cyc = 0;

  always #2.5 clk = ~clk;

  i2c_ctl_regs i_i2c_ctl_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cfg_err(cfg_err), .ev_byte_done(ev_byte_done), .ev_addr_match(ev_addr_match),
    .ev_arb_lost(ev_arb_lost), .rx_mode(rx_mode), .scl_tick(scl_tick),
    .scl_hold(scl_hold), .ack_sda(ack_sda), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic write(input logic [7:0] v);
    wr_data = v;
    wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  // Driver side of the scoreboard: expected tick intervals after a write
  task automatic timed_write(input logic [7:0] v, input int period);
    write(v);
    exp_q.push_back(period + 1);
    exp_q.push_back(period);
    exp_q.push_back(period);
    repeat (3 * period + 20) step();
    check("R4 all ticks seen", exp_q.size(), 0);
  endtask

  // Monitor side: measure cycles between ticks and compare with the queue
  always @(posedge clk) begin
    if (rst || wr_en) begin
      cyc = 0;
    end else begin
      cyc++;
      if (scl_tick) begin
        if (exp_q.size() > 0) begin
          check("R4 tick interval", cyc, exp_q.pop_front());
        end
        cyc = 0;
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    check("R1 rd_data", rd_data, 8'h0F);
    check("R1 irq", irq, 0);
    check("R1 scl_hold", scl_hold, 0);
    check("R1 cfg_err", cfg_err, 0);
    check("R1 ack_sda", ack_sda, 1);

    // R2 field storage
    write(8'hA7);
    check("R2 readback", rd_data, 8'hA7);
    write(8'h25);
    check("R2 readback ie", rd_data, 8'h25);

    // R5 byte done, R7 hold, R9 irq one cycle later
    ev_byte_done = 1'b1; step(); ev_byte_done = 1'b0;
    check("R5 pend after byte", rd_data[4], 1);
    check("R7 hold set", scl_hold, 1);
    check("R9 irq not yet", irq, 0);
    step();
    check("R9 irq set", irq, 1);

    // R6 writing one keeps it set, writing zero clears
    write(8'h35);
    check("R6 write one keeps set", rd_data[4], 1);
    write(8'h25);
    check("R6 write zero clears", rd_data[4], 0);
    check("R7 hold released", scl_hold, 0);
    step();
    check("R9 irq drops", irq, 0);
    write(8'h35);
    check("R6 write one does not set", rd_data[4], 0);
    check("R7 hold stays low", scl_hold, 0);

    ev_addr_match = 1'b1; step(); ev_addr_match = 1'b0;
    check("R5 pend after match", rd_data[4], 1);
    write(8'h25);
    ev_arb_lost = 1'b1; step(); ev_arb_lost = 1'b0;
    check("R5 pend after arb lost", rd_data[4], 1);
    write(8'h25);

    // R8 set and clear in one cycle
    ev_byte_done = 1'b1;
    write(8'h25);
    ev_byte_done = 1'b0;
    check("R8 set wins", rd_data[4], 1);
    check("R8 hold", scl_hold, 1);

    // R9 interrupt disabled still records
    write(8'h05);
    ev_byte_done = 1'b1; step(); ev_byte_done = 1'b0;
    check("R9 pend recorded ie=0", rd_data[4], 1);
    step();
    check("R9 irq off ie=0", irq, 0);
    write(8'h05);

    // R10 acknowledge slot
    rx_mode = 1'b1;
    write(8'h85);
    step();
    check("R10 rx ack drives low", ack_sda, 0);
    rx_mode = 1'b0; step();
    check("R10 tx releases", ack_sda, 1);
    rx_mode = 1'b1;
    write(8'h05);
    step();
    check("R10 ack off releases", ack_sda, 1);
    rx_mode = 1'b0;

    // R3 clamp
    check("R3 no error yet", cfg_err, 0);
    write(8'h01);
    check("R3 clamp to 2", rd_data[3:0], 2);
    check("R3 cfg_err set", cfg_err, 1);
    write(8'h40);
    check("R3 slow allows 0", rd_data[3:0], 0);
    check("R3 cfg_err sticky", cfg_err, 1);
    write(8'h41);
    check("R3 slow allows 1", rd_data[3:0], 1);

    // R4 tick periods
    timed_write(8'h03, 8 * 4);
    timed_write(8'h00, 8 * 3);
    timed_write(8'h40, 256 * 1);
    timed_write(8'h45, 256 * 6);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule